// File: doc/BRIEF.md
# Two-Phase Fetch/Execute Sequencer

This block is the control core of a small CPU whose instructions and data live in one memory behind one port. Because the port can serve only one access per cycle, the sequencer splits every instruction into two clock cycles. In the first cycle, the fetch phase, it puts the program counter on the memory address and latches the returned word into a private instruction register. In the second cycle, the execute phase, it decodes that register, steers the memory port to the data address coming from the ALU, and raises the register-file and PC write strobes. Every result is committed on the rising edge that closes the execute cycle.

The ALU and the register file sit outside the block. The datapath feeds in the ALU result, the store operand and the branch condition. The sequencer hands back the decoded register indices, the sign-extended immediate, the ALU operation, the operand select, the write-back value and its strobes. The program counter is held inside the block and shown on a port.

Top module: `fetch_exec_ctl`

## Requirements
- R1: A synchronous reset puts the block in the fetch phase (`fetch_phase`=1) with the PC at 0 and the instruction register at 0.
- R2: The phase alternates strictly, so every instruction takes two cycles: fetch, then execute, then fetch again.
- R3: In the fetch phase, `mem_addr` equals `pc`, `mem_re`=1, `mem_wdata`=0, and `mem_we`, `reg_we` and `pc_we` are all 0.
- R4: On the edge that ends fetch, `mem_rdata` is loaded into the instruction register (`ir`), which then holds through the execute cycle and the next fetch cycle.
- R5: In the execute phase, `mem_addr` equals `alu_result` and `mem_wdata` equals `store_data`.
- R6: Write-back is enabled in execute only for opcode bits [31:26] = 0x00 (destination `ir[15:11]`), 0x08 and 0x23 (destination `ir[20:16]`). `reg_wdata` is `mem_rdata` for 0x23 and `alu_result` otherwise.
- R7: In execute, `mem_we`=1 only for opcode 0x2B and `mem_re`=1 only for opcode 0x23.
- R8: In execute, for opcode 0x00 `alu_op` is `ir[5:0]` and `alu_src_imm`=0. For 0x08, 0x23 and 0x2B, `alu_op`=0x20 and `alu_src_imm`=1. For 0x04, `alu_op`=0x22. `imm_ext` is `ir[15:0]` sign-extended.
- R9: The PC changes only at the end of execute (`pc_we`=1 there). It becomes PC+4 by default. For opcode 0x04 with `branch_cond`=1 it becomes PC+4+(sign-extended `ir[15:0]` shifted left by 2). For opcode 0x02 it becomes {(PC+4)[31:28], `ir[25:0]`, 2'b00}.
- R10: Any other opcode writes neither the register file nor memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 32 | Shared memory address |
| mem_wdata | output | 32 | Shared memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Memory read data, valid in the same cycle |
| alu_result | input | 32 | ALU result, used as the data address |
| store_data | input | 32 | Register operand to store |
| branch_cond | input | 1 | Branch condition from the datapath |
| fetch_phase | output | 1 | 1 in the fetch cycle, 0 in the execute cycle |
| pc | output | 32 | Program counter |
| ir | output | 32 | Instruction register |
| rs_idx | output | 5 | First source register index |
| rt_idx | output | 5 | Second source register index |
| shamt | output | 5 | Shift amount field |
| imm_ext | output | 32 | Sign-extended immediate |
| alu_op | output | 6 | ALU operation code |
| alu_src_imm | output | 1 | Second ALU operand is the immediate |
| reg_we | output | 1 | Register-file write strobe |
| reg_waddr | output | 5 | Register-file write index |
| reg_wdata | output | 32 | Register-file write data |
| pc_we | output | 1 | PC update strobe |

## Verification
Two functions share a single execute cycle. For a load, the data read and the register write-back happen together. For a store, the memory write and the PC update close on the same edge. The bench provokes both by sweeping all 64 opcodes with both branch-condition values, and all 64 function codes of the register form. In each execute cycle it drives different values on `alu_result`, `store_data` and `mem_rdata`. It checks that the address is the data address, that the write-back value comes from the right source, and that the PC still shows the old value. In the following fetch cycle it checks that the address has moved to the PC it computed itself.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

    localparam int INSTR_W = 32;
    localparam int OPC_W   = 6;
    localparam int REG_W   = 5;
    localparam int IMM_W   = 16;
    localparam int TGT_W   = 26;

    localparam logic [OPC_W-1:0] OP_REG   = 6'h00;
    localparam logic [OPC_W-1:0] OP_JUMP  = 6'h02;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OP_STORE = 6'h2B;

    localparam logic [5:0] ALU_ADD = 6'h20;
    localparam logic [5:0] ALU_SUB = 6'h22;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef struct packed {
        logic [OPC_W-1:0] opcode;
        logic [REG_W-1:0] rs;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] shamt;
        logic [5:0]       funct;
        logic [IMM_W-1:0] imm;
        logic [TGT_W-1:0] target;
    } fields_t;

    typedef struct packed {
        logic       reg_we;
        logic       dest_is_rd;
        logic       wb_from_mem;
        logic       mem_we;
        logic       mem_re;
        logic       alu_src_imm;
        logic [5:0] alu_op;
        logic       cond_branch;
        logic       jump;
    } ctl_t;

endpackage

// File: rtl/fxc_decode.sv
module fxc_decode
    import fxc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output fields_t            fld,
    output ctl_t               ctl
);

    // Field split: every format sliced at once, consumers pick what they need
    always_comb begin
        fld.opcode = instr[31:26];
        fld.rs     = instr[25:21];
        fld.rt     = instr[20:16];
        fld.rd     = instr[15:11];
        fld.shamt  = instr[10:6];
        fld.funct  = instr[5:0];
        fld.imm    = instr[15:0];
        fld.target = instr[25:0];
    end

    // Opcode to control word
    always_comb begin
        ctl = '0;
        case (instr[31:26])
            OP_REG: begin
                ctl.reg_we     = 1'b1;
                ctl.dest_is_rd = 1'b1;
                ctl.alu_op     = instr[5:0];
            end
            OP_ADDI: begin
                ctl.reg_we      = 1'b1;
                ctl.alu_src_imm = 1'b1;
                ctl.alu_op      = ALU_ADD;
            end
            OP_LOAD: begin
                ctl.reg_we      = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.mem_re      = 1'b1;
                ctl.alu_src_imm = 1'b1;
                ctl.alu_op      = ALU_ADD;
            end
            OP_STORE: begin
                ctl.mem_we      = 1'b1;
                ctl.alu_src_imm = 1'b1;
                ctl.alu_op      = ALU_ADD;
            end
            OP_BEQ: begin
                ctl.cond_branch = 1'b1;
                ctl.alu_op      = ALU_SUB;
            end
            OP_JUMP: begin
                ctl.jump = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    // A store never writes back; a load is the only memory source (R6, R7)
    always_comb begin
        assert_store_no_wb_R6: assert (!(ctl.mem_we && (ctl.reg_we || ctl.mem_re)));
    end

endmodule

// File: rtl/fxc_next_pc.sv
module fxc_next_pc
    import fxc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  pc_cur,
    input  logic [XLEN-1:0]  imm_ext,
    input  logic [TGT_W-1:0] target,
    input  logic             cond_branch,
    input  logic             jump,
    input  logic             branch_cond,
    output logic [XLEN-1:0]  pc_nxt
);

    localparam int SEG_LO = TGT_W + 2;

    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] pc_br;
    logic [XLEN-1:0] pc_jmp;

    always_comb begin
        pc_seq = pc_cur + XLEN'(4);
        pc_br  = pc_seq + {imm_ext[XLEN-3:0], 2'b00};
        pc_jmp = {pc_seq[XLEN-1:SEG_LO], target, 2'b00};
        if (jump)
            pc_nxt = pc_jmp;
        else if (cond_branch && branch_cond)
            pc_nxt = pc_br;
        else
            pc_nxt = pc_seq;
    end

endmodule

// File: rtl/fetch_exec_ctl.sv
module fetch_exec_ctl
    import fxc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    output logic             mem_we,
    output logic             mem_re,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic [XLEN-1:0]  alu_result,
    input  logic [XLEN-1:0]  store_data,
    input  logic             branch_cond,
    output logic             fetch_phase,
    output logic [XLEN-1:0]  pc,
    output logic [INSTR_W-1:0] ir,
    output logic [REG_W-1:0] rs_idx,
    output logic [REG_W-1:0] rt_idx,
    output logic [REG_W-1:0] shamt,
    output logic [XLEN-1:0]  imm_ext,
    output logic [5:0]       alu_op,
    output logic             alu_src_imm,
    output logic             reg_we,
    output logic [REG_W-1:0] reg_waddr,
    output logic [XLEN-1:0]  reg_wdata,
    output logic             pc_we
);

    localparam int IMM_PAD = XLEN - IMM_W;

    typedef struct packed {
        phase_e             phase;
        logic [XLEN-1:0]    pc;
        logic [INSTR_W-1:0] ir;
    } seq_t;

    seq_t    cur_q, cur_d;
    fields_t fld;
    ctl_t    ctl;
    logic [XLEN-1:0] pc_nxt;
    logic            in_exec;

    fxc_decode u_decode (
        .instr (cur_q.ir),
        .fld   (fld),
        .ctl   (ctl)
    );

    fxc_next_pc #(.XLEN(XLEN)) u_next_pc (
        .pc_cur      (cur_q.pc),
        .imm_ext     (imm_ext),
        .target      (fld.target),
        .cond_branch (ctl.cond_branch),
        .jump        (ctl.jump),
        .branch_cond (branch_cond),
        .pc_nxt      (pc_nxt)
    );

    assign in_exec = (cur_q.phase == PH_EXEC);

    // Next-state computation
    always_comb begin
        cur_d = cur_q;
        case (cur_q.phase)
            PH_FETCH: begin
                cur_d.ir    = mem_rdata;
                cur_d.phase = PH_EXEC;
            end
            default: begin
                cur_d.pc    = pc_nxt;
                cur_d.phase = PH_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.phase <= PH_FETCH;
            cur_q.pc    <= '0;
            cur_q.ir    <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    // Output steering
    always_comb begin
        imm_ext     = {{IMM_PAD{fld.imm[IMM_W-1]}}, fld.imm};
        fetch_phase = !in_exec;
        pc          = cur_q.pc;
        ir          = cur_q.ir;
        rs_idx      = fld.rs;
        rt_idx      = fld.rt;
        shamt       = fld.shamt;
        alu_op      = ctl.alu_op;
        alu_src_imm = ctl.alu_src_imm;
        reg_waddr   = ctl.dest_is_rd ? fld.rd : fld.rt;
        reg_wdata   = ctl.wb_from_mem ? mem_rdata : alu_result;
        if (in_exec) begin
            mem_addr  = alu_result;
            mem_wdata = store_data;
            mem_we    = ctl.mem_we;
            mem_re    = ctl.mem_re;
            reg_we    = ctl.reg_we;
            pc_we     = 1'b1;
        end else begin
            mem_addr  = cur_q.pc;
            mem_wdata = '0;
            mem_we    = 1'b0;
            mem_re    = 1'b1;
            reg_we    = 1'b0;
            pc_we     = 1'b0;
        end
    end

    // Checks on the sequencing
    assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cur_q.phase != $past(cur_q.phase)));

    assert_fetch_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        fetch_phase |-> (!mem_we && !reg_we && !pc_we));

    assert_ir_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_EXEC) |=> $stable(cur_q.ir));

    assert_store_only_R7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (in_exec && fld.opcode == OP_STORE));

    assert_pc_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cur_q.phase == PH_FETCH) |=> $stable(cur_q.pc));

    assert_pc_aligned_R9: assert property (@(posedge clk) disable iff (rst)
        cur_q.pc[1:0] == 2'b00);

endmodule

// File: tb/fetch_exec_ctl_test.sv
module fetch_exec_ctl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, alu_result, store_data;
    logic        mem_we, mem_re, branch_cond, fetch_phase;
    logic [31:0] pc, ir, imm_ext, reg_wdata;
    logic [4:0]  rs_idx, rt_idx, shamt, reg_waddr;
    logic [5:0]  alu_op;
    logic        alu_src_imm, reg_we, pc_we;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] exp_pc = 32'h0;

    always #5 clk = ~clk;

    fetch_exec_ctl uut (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .alu_result(alu_result), .store_data(store_data),
        .branch_cond(branch_cond), .fetch_phase(fetch_phase), .pc(pc), .ir(ir),
        .rs_idx(rs_idx), .rt_idx(rt_idx), .shamt(shamt), .imm_ext(imm_ext),
        .alu_op(alu_op), .alu_src_imm(alu_src_imm), .reg_we(reg_we),
        .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .pc_we(pc_we)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One instruction: fetch cycle, then execute cycle; starts and ends just after a falling edge
    task automatic run_instr(input logic [31:0] instr, input logic [31:0] alu,
                             input logic [31:0] sd, input logic [31:0] ld, input bit cond);
        logic [5:0]  op;
        logic [31:0] sx, pc4, nxt;
        bit e_rw, e_rd, e_ld, e_st, e_imm;
        logic [5:0] e_alu;
        op  = instr[31:26];
        sx  = {{16{instr[15]}}, instr[15:0]};
        e_rw = (op == 6'h00) || (op == 6'h08) || (op == 6'h23);
        e_rd = (op == 6'h00);
        e_ld = (op == 6'h23);
        e_st = (op == 6'h2B);
        e_imm = (op == 6'h08) || e_ld || e_st;
        e_alu = (op == 6'h00) ? instr[5:0] : e_imm ? 6'h20 : (op == 6'h04) ? 6'h22 : 6'h00;
        pc4 = exp_pc + 32'd4;
        if (op == 6'h02)            nxt = {pc4[31:28], instr[25:0], 2'b00};
        else if (op == 6'h04 && cond) nxt = pc4 + (sx << 2);
        else                        nxt = pc4;

        // fetch cycle
        mem_rdata = instr; alu_result = ~alu; store_data = ~sd; branch_cond = ~cond;
        #1;
        chk(fetch_phase == 1'b1, "R2 fetch phase", {31'b0, fetch_phase}, 32'd1);
        chk(mem_addr == exp_pc, "R3 fetch address", mem_addr, exp_pc);
        chk(mem_we == 0 && reg_we == 0 && pc_we == 0 && mem_re == 1 && mem_wdata == 0,
            "R3 fetch strobes", {mem_we, reg_we, pc_we, mem_re}, 32'b0001);
        @(negedge clk);
        // execute cycle
        mem_rdata = ld; alu_result = alu; store_data = sd; branch_cond = cond;
        #1;
        chk(fetch_phase == 1'b0, "R2 execute phase", {31'b0, fetch_phase}, 32'd0);
        chk(ir == instr, "R4 instruction register", ir, instr);
        chk(mem_addr == alu && mem_wdata == sd, "R5 data address", mem_addr, alu);
        chk(mem_we == e_st, "R7 write strobe", {31'b0, mem_we}, {31'b0, e_st});
        chk(mem_re == e_ld, "R7 read strobe", {31'b0, mem_re}, {31'b0, e_ld});
        chk(reg_we == e_rw, (e_rw ? "R6 write-back" : "R10 no write-back"), {31'b0, reg_we}, {31'b0, e_rw});
        if (e_rw) begin
            chk(reg_waddr == (e_rd ? instr[15:11] : instr[20:16]), "R6 destination",
                {27'b0, reg_waddr}, {27'b0, (e_rd ? instr[15:11] : instr[20:16])});
            chk(reg_wdata == (e_ld ? ld : alu), "R6 write-back data", reg_wdata, (e_ld ? ld : alu));
        end
        if (e_rw || e_st || op == 6'h04) begin
            chk(alu_op == e_alu && alu_src_imm == e_imm, "R8 alu control",
                {25'b0, alu_src_imm, alu_op}, {25'b0, e_imm, e_alu});
        end
        chk(imm_ext == sx && rs_idx == instr[25:21] && rt_idx == instr[20:16] && shamt == instr[10:6],
            "R8 fields", imm_ext, sx);
        chk(pc_we == 1'b1 && pc == exp_pc, "R9 pc held in execute", pc, exp_pc);
        @(negedge clk);
        exp_pc = nxt;
        chk(pc == exp_pc, "R9 next pc", pc, exp_pc);
    endtask

    initial begin
        mem_rdata = 32'hDEAD_BEEF; alu_result = 0; store_data = 0; branch_cond = 0;
        repeat (2) @(negedge clk);
        #1;
        chk(pc == 0 && ir == 0 && fetch_phase == 1, "R1 reset state", ir, 32'h0);
        rst = 1'b0;
        // all opcodes, both condition values
        for (int op = 0; op < 64; op++) begin
            for (int k = 0; k < 2; k++) begin
                logic [31:0] w;
                w = 32'h02A5_F1C3 * (op + 1) + k * 32'h0135_79BD;
                run_instr({op[5:0], w[25:0]}, 32'h1000_0000 + op * 16 + k,
                          32'h5A00_0000 ^ (op * 3), 32'hC000_0000 | (op << 4) | k, k[0]);
            end
        end
        // register-form function codes
        for (int f = 0; f < 64; f++) begin
            run_instr({6'h00, 5'(f), 5'(f + 3), 5'(f + 7), 5'(f * 5), f[5:0]},
                      32'h2000_0000 + f, 32'h3000_0000 + f, 32'h4000_0000 + f, f[0]);
        end
        // branch backwards and forwards, taken and not taken
        run_instr({6'h04, 10'h0, 16'hFFF0}, 0, 0, 0, 1'b1);
        run_instr({6'h04, 10'h0, 16'h0010}, 0, 0, 0, 1'b1);
        run_instr({6'h04, 10'h0, 16'h8000}, 0, 0, 0, 1'b0);
        // reset in the middle of an execute cycle
        mem_rdata = 32'h8C00_0000;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk(pc == 0 && ir == 0 && fetch_phase == 1, "R1 reset mid-instruction", pc, 32'h0);
        rst = 1'b0;
        exp_pc = 0;
        run_instr({6'h2B, 26'h1234567}, 32'h0000_0100, 32'hABCD_0123, 32'h0, 1'b0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule